// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block is the digital half of a supply supervisor for a microcontroller core. Three comparators outside the block report, as raw level flags, whether the supply is below a warning level, below the minimum operating level, or below the backup battery level. The block synchronizes these flags and escalates in three steps. The first step is a one-shot warning interrupt request that leaves the processor running. The second step holds the processor in reset, drives the shared reset pin low and blocks all memory chip enables and the write strobe. The third step signals that the supply has switched to the battery.

When the supply recovers, and after the block's own reset is released, the processor reset is held for a fixed power-on delay counted in clocks. The reset pin can be driven from both sides. Any device on the board that pulls it low also resets this processor, so several supervisors can enter their power-down resets together. The interrupt vector address for the warning is presented alongside the request.

Top module: `pwr_supervisor`

## Requirements
- R1: After `rst_n` is released with all supply flags low, `cpu_rst` stays 1 for exactly POR_CYCLES (default 21504) rising edges and reads 0 after that edge. While `rst_n` is low: `cpu_rst`=1, `warn_irq`=0, `bat_sw_n`=1, `ce_inhibit`=0, `rstio_drive_low`=0.
- R2: A rise of `warn_raw` while `warn_en`=1 and the processor is running gives `warn_irq`=1 for exactly one cycle, after the third rising edge. `warn_vector` reads 16'h002B.
- R3: No further pulse is given while `warn_raw` stays high. A new pulse needs `warn_raw` to go low and then rise again.
- R4: If `warn_en`=0 when `warn_raw` rises, no pulse is given, even if `warn_en` is set later while the warning persists.
- R5: When `vmin_raw` rises, `cpu_rst`, `rstio_drive_low` and `ce_inhibit` all read 1 after the third rising edge (and not after the second). They stay 1 while `vmin_raw` is high.
- R6: When `vmin_raw` falls, `rstio_drive_low` and `ce_inhibit` read 0 after the third edge. `cpu_rst` stays 1 and reads 0 only after edge POR_CYCLES+3.
- R7: A rise of `vmin_raw` during the power-on delay returns the block to the fail state (`ce_inhibit`=1). The delay restarts from zero after the next fall.
- R8: `rstio_in`=0 forces `cpu_rst`=1 by the second rising edge without setting `ce_inhibit` or `rstio_drive_low`. When `rstio_in` returns to 1, `cpu_rst` is released.
- R9: `bat_sw_n` follows the inverse of `bat_raw` with three edges of latency (0 means running from the battery). It does not depend on the other inputs.
- R10: A warning that begins while the processor is held in supply-fail reset produces no pulse, either during the reset or after recovery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| warn_raw | input | 1 | Comparator: supply below warning level (async) |
| vmin_raw | input | 1 | Comparator: supply below minimum operating level (async) |
| bat_raw | input | 1 | Comparator: supply below battery level (async) |
| warn_en | input | 1 | Warning interrupt enable |
| rstio_in | input | 1 | Sensed level of the shared reset pin, low = reset requested |
| warn_irq | output | 1 | One-cycle warning interrupt request |
| warn_vector | output | 16 | Vector address for the warning interrupt |
| cpu_rst | output | 1 | Processor reset, active high |
| rstio_drive_low | output | 1 | Enable for the open-drain pull-down on the reset pin |
| bat_sw_n | output | 1 | Low while the supply is switched to the battery |
| ce_inhibit | output | 1 | Forces chip enables and write strobe inactive |

## Verification
The sequencer's state is visible at the ports. A fail state that is entered late or left early shows up on `ce_inhibit` and `rstio_drive_low` within three edges of the comparator change. A power-on counter that is off by one, or that fails to restart, moves the falling edge of `cpu_rst`, so the delay is measured to the exact edge both after block reset and after supply recovery. A lost or stuck arming of the edge detector shows up as a missing, doubled or unexpected `warn_irq` pulse, either on the third edge after the warning rises or during a watch window afterwards.

// File: rtl/pwrsup_pkg.sv
// Shared types for the power-fail supervisor.
// Assumes: nothing; types only.
package pwrsup_pkg;
    // Supervisor sequencing states.
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,  // counting power-on delay, processor held in reset
        ST_RUN  = 2'd1,  // normal operation
        ST_FAIL = 2'd2   // supply below minimum, reset pin driven low
    } sup_state_t;
endpackage

// File: rtl/pwrsup_sync.sv
// Multi-bit, multi-stage synchronizer for independent level flags.
// Assumes: each bit is a slow level with no relation to the other bits,
// so per-bit metastability resolution is enough; RST_VAL sets the
// level each bit reads while the block reset is active.
module pwrsup_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d_async;
    end

    // Remaining stages form the resolution chain.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stg[s] <= RST_VAL;
            else        stg[s] <= stg[s-1];
        end
    end

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/pwrsup_seq.sv
// Reset sequencer: fail / power-on delay / run state machine.
// Assumes: vmin_s is already synchronized; the block reset is treated as
// a power-up and starts the power-on delay from zero.
module pwrsup_seq
    import pwrsup_pkg::*;
#(
    parameter int POR_CYCLES = 21504
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vmin_s,
    output sup_state_t state
);
    localparam int CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

    logic [CW-1:0] cnt;

    // State and delay counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_POR;
            cnt   <= '0;
        end else if (vmin_s) begin
            state <= ST_FAIL;
            cnt   <= '0;
        end else begin
            case (state)
                ST_FAIL: begin
                    state <= ST_POR;
                    cnt   <= '0;
                end
                ST_POR: begin
                    if (cnt == LAST) state <= ST_RUN;
                    else             cnt   <= cnt + 1'b1;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/pwrsup_warn.sv
// Warning interrupt generator: one pulse per entry into the warning level.
// Assumes: warn_s is synchronized; a pulse is only given while the
// processor runs, and only on the edge itself, so enabling later or
// leaving reset during a persisting warning gives no pulse.
module pwrsup_warn (
    input  logic clk,
    input  logic rst_n,
    input  logic warn_s,
    input  logic irq_en,
    input  logic running,
    output logic warn_prev,
    output logic irq
);
    // Remember the previous warning level and issue the edge pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            warn_prev <= 1'b0;
            irq       <= 1'b0;
        end else begin
            warn_prev <= warn_s;
            irq       <= warn_s & ~warn_prev & irq_en & running;
        end
    end
endmodule

// File: rtl/pwr_supervisor.sv
// Power-fail supervisor top: synchronizes comparator flags and drives
// the warning request, processor reset, reset pin pull-down, battery
// indication and chip-enable inhibit.
// Assumes: flags are active high (supply below level); rstio_in is the
// sensed pin level, including this block's own pull-down.
module pwr_supervisor
    import pwrsup_pkg::*;
#(
    parameter int          POR_CYCLES  = 21504,
    parameter int          SYNC_STAGES = 2,
    parameter logic [15:0] WARN_VECTOR = 16'h002B
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        warn_raw,
    input  logic        vmin_raw,
    input  logic        bat_raw,
    input  logic        warn_en,
    input  logic        rstio_in,
    output logic        warn_irq,
    output logic [15:0] warn_vector,
    output logic        cpu_rst,
    output logic        rstio_drive_low,
    output logic        bat_sw_n,
    output logic        ce_inhibit
);
    localparam int NFLAG = 4;

    logic [NFLAG-1:0] flags_s;
    logic             warn_s, vmin_s, bat_s, rstio_s;
    logic             warn_prev;
    sup_state_t       state;

    pwrsup_sync #(
        .WIDTH  (NFLAG),
        .STAGES (SYNC_STAGES),
        .RST_VAL(4'b1000)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async({rstio_in, bat_raw, vmin_raw, warn_raw}),
        .q_sync (flags_s)
    );

    assign {rstio_s, bat_s, vmin_s, warn_s} = flags_s;

    pwrsup_seq #(.POR_CYCLES(POR_CYCLES)) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .vmin_s(vmin_s),
        .state (state)
    );

    pwrsup_warn u_warn (
        .clk      (clk),
        .rst_n    (rst_n),
        .warn_s   (warn_s),
        .irq_en   (warn_en),
        .running  (state == ST_RUN),
        .warn_prev(warn_prev),
        .irq      (warn_irq)
    );

    // Battery indication, registered so it is glitch-free at the pin.
    always_ff @(posedge clk) begin
        if (!rst_n) bat_sw_n <= 1'b1;
        else        bat_sw_n <= ~bat_s;
    end

    // Reset and inhibit outputs decoded from the sequencer state.
    always_comb begin
        cpu_rst         = (state != ST_RUN) | ~rstio_s;
        rstio_drive_low = (state == ST_FAIL);
        ce_inhibit      = (state == ST_FAIL);
    end

    assign warn_vector = WARN_VECTOR;
endmodule

// File: rtl/pwrsup_checker.sv
// Property checker for pwr_supervisor, attached by bind.
// Assumes: observes synchronized flags and ports only.
module pwrsup_checker (
    input logic clk,
    input logic rst_n,
    input logic warn_s,
    input logic vmin_s,
    input logic bat_s,
    input logic rstio_s,
    input logic warn_irq,
    input logic cpu_rst,
    input logic rstio_drive_low,
    input logic bat_sw_n,
    input logic ce_inhibit
);
    // R2: a pulse only follows a synchronized warning level
    a_r2_irq_needs_warn: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> $past(warn_s));

    // R3: the request is a single-cycle pulse
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |=> !warn_irq);

    // R5: a low supply puts every fail output into effect on the next edge
    a_r5_fail_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        vmin_s |=> (cpu_rst && rstio_drive_low && ce_inhibit));

    // R8: an external pull on the reset pin always resets the processor
    a_r8_ext_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !rstio_s |-> cpu_rst);

    // R9: the battery indication falls one edge after the synchronized flag rises
    a_r9_bat_switch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bat_s) |=> !bat_sw_n);

    // R5: chip enables are never blocked while the processor runs
    a_r5_inhibit_only_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rst |-> !ce_inhibit);
endmodule

bind pwr_supervisor pwrsup_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .warn_s         (warn_s),
    .vmin_s         (vmin_s),
    .bat_s          (bat_s),
    .rstio_s        (rstio_s),
    .warn_irq       (warn_irq),
    .cpu_rst        (cpu_rst),
    .rstio_drive_low(rstio_drive_low),
    .bat_sw_n       (bat_sw_n),
    .ce_inhibit     (ce_inhibit)
);

// File: tb/tb_pwr_supervisor.sv
module tb_pwr_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int POR        = 21504;
    localparam int WDOG       = 190000;

    // Vector fields: [3] bat_raw, [2] external pull on reset pin,
    // [1] expected cpu_rst, [0] expected bat_sw_n
    localparam logic [3:0] VEC [5] = '{4'b0001, 4'b1000, 4'b1110, 4'b0111, 4'b0001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warn_raw = 1'b0, vmin_raw = 1'b0, bat_raw = 1'b0, warn_en = 1'b0;
    logic        ext_pull = 1'b0;
    logic        rstio_in;
    logic        warn_irq, cpu_rst, rstio_drive_low, bat_sw_n, ce_inhibit;
    logic [15:0] warn_vector;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    assign rstio_in = ~(ext_pull | rstio_drive_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_supervisor dut (
        .clk(clk), .rst_n(rst_n), .warn_raw(warn_raw), .vmin_raw(vmin_raw),
        .bat_raw(bat_raw), .warn_en(warn_en), .rstio_in(rstio_in),
        .warn_irq(warn_irq), .warn_vector(warn_vector), .cpu_rst(cpu_rst),
        .rstio_drive_low(rstio_drive_low), .bat_sw_n(bat_sw_n), .ce_inhibit(ce_inhibit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // Count edges until cpu_rst reads 0; record outputs after edge 3.
    task automatic measure(output int n, output logic r3, output logic c3, output logic d3);
        n = 0; r3 = 1'b0; c3 = 1'b1; d3 = 1'b1;
        while (n < 30000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n == 3) begin r3 = cpu_rst; c3 = ce_inhibit; d3 = rstio_drive_low; end
            if (!cpu_rst) break;
        end
    endtask

    // Watch for any request pulse over a window of edges.
    task automatic watch(input int n, output logic seen);
        seen = 1'b0;
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
            seen |= warn_irq;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WDOG);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int   n;
        logic r3, c3, d3, seen;

        // Reset state, R1
        edges(4);
        chk("R1 reset cpu_rst", cpu_rst, 1);
        chk("R1 reset warn_irq", warn_irq, 0);
        chk("R1 reset bat_sw_n", bat_sw_n, 1);
        chk("R1 reset ce_inhibit", ce_inhibit, 0);
        chk("R1 reset rstio_drive_low", rstio_drive_low, 0);
        rst_n = 1'b1;
        measure(n, r3, c3, d3);
        chk("R1 power-on delay", n, POR);

        // Table: battery and external reset pin combinations, R8 R9
        for (int i = 0; i < 5; i++) begin
            bat_raw  = VEC[i][3];
            ext_pull = VEC[i][2];
            edges(4);
            chk($sformatf("R8 vec%0d cpu_rst", i), cpu_rst, VEC[i][1]);
            chk($sformatf("R9 vec%0d bat_sw_n", i), bat_sw_n, VEC[i][0]);
            chk($sformatf("R8 vec%0d ce_inhibit", i), ce_inhibit, 0);
        end
        // R9 latency: low only after the third edge
        bat_raw = 1'b1;
        edges(2);
        chk("R9 bat latency edge2", bat_sw_n, 1);
        edges(1);
        chk("R9 bat latency edge3", bat_sw_n, 0);
        bat_raw = 1'b0;
        // R8 latency: cpu_rst by second edge, pin not driven by block
        ext_pull = 1'b1;
        edges(2);
        chk("R8 ext latency", cpu_rst, 1);
        chk("R8 no drive", rstio_drive_low, 0);
        ext_pull = 1'b0;
        edges(4);
        chk("R8 release", cpu_rst, 0);

        // Warning pulse, R2
        warn_en  = 1'b1;
        warn_raw = 1'b1;
        edges(2);
        chk("R2 no pulse at edge2", warn_irq, 0);
        edges(1);
        chk("R2 pulse at edge3", warn_irq, 1);
        chk("R2 vector", warn_vector, 16'h002B);
        edges(1);
        chk("R2 pulse one cycle", warn_irq, 0);
        watch(20, seen);
        chk("R3 no repeat while warning", seen, 0);
        // Re-arm after recovery, R3
        warn_raw = 1'b0;
        edges(4);
        warn_raw = 1'b1;
        edges(3);
        chk("R3 re-armed pulse", warn_irq, 1);
        // Disabled at entry, R4
        warn_raw = 1'b0;
        edges(4);
        warn_en  = 1'b0;
        warn_raw = 1'b1;
        watch(4, seen);
        chk("R4 disabled no pulse", seen, 0);
        warn_en = 1'b1;
        watch(8, seen);
        chk("R4 late enable no pulse", seen, 0);
        warn_raw = 1'b0;
        edges(4);

        // Supply fail, R5
        vmin_raw = 1'b1;
        edges(2);
        chk("R5 not yet at edge2", ce_inhibit, 0);
        edges(1);
        chk("R5 cpu_rst", cpu_rst, 1);
        chk("R5 rstio_drive_low", rstio_drive_low, 1);
        chk("R5 ce_inhibit", ce_inhibit, 1);
        // Warning during reset, R10
        warn_raw = 1'b1;
        watch(10, seen);
        chk("R10 no pulse in reset", seen, 0);
        chk("R5 held", ce_inhibit, 1);

        // Recovery, R6 and R10
        vmin_raw = 1'b0;
        measure(n, r3, c3, d3);
        chk("R6 delay after recovery", n, POR + 3);
        chk("R6 cpu_rst held at edge3", r3, 1);
        chk("R6 ce_inhibit released", c3, 0);
        chk("R6 pin released", d3, 0);
        watch(10, seen);
        chk("R10 no pulse after recovery", seen, 0);
        warn_raw = 1'b0;

        // Restart of the delay, R7
        vmin_raw = 1'b1;
        edges(5);
        vmin_raw = 1'b0;
        edges(1000);
        chk("R7 still in delay", cpu_rst, 1);
        vmin_raw = 1'b1;
        edges(5);
        chk("R7 back to fail", ce_inhibit, 1);
        vmin_raw = 1'b0;
        measure(n, r3, c3, d3);
        chk("R7 delay restarted", n, POR + 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule